// File: doc/BRIEF.md
# Mailbox Interrupt Flag Controller

This block sits beside a three-port shared memory and turns writes to two reserved mailbox words into interrupts between the ports. The first port addresses the memory through one of two bank enables. The second and third ports each own one bank and select it with a single chip enable. A write to a mailbox word raises a sticky flag towards the receiving port. The flag stays up until the receiving port touches the same word.

The first port receives two interrupts, one from each of the other ports. Each of the other ports receives one interrupt from the first port, and which of them receives it depends on the bank enable the first port used for the write. The second-highest word of the address space is the mailbox that the first port reads. The highest word is the mailbox that the other ports read. All port signals are active-low strobes sampled on one clock. Flags change on the clock edge that follows the qualifying access.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: While rst_ni is low, all four interrupt outputs are high (inactive), and they stay high after reset until a set condition occurs.
- R2: A clock edge that samples p2_ce_n_i=0, p2_wr_n_i=0 and p2_addr_i=0xFFE drives irq_p1_from_p2_n_o low from that edge on.
- R3: A clock edge that samples p3_ce_n_i=0, p3_wr_n_i=0 and p3_addr_i=0xFFE drives irq_p1_from_p3_n_o low from that edge on.
- R4: A port-1 write (p1_wr_n_i=0) to 0xFFF drives irq_p2_n_o low when p1_bank_n_i=2'b10 (bank 0 only) and drives irq_p3_n_o low when p1_bank_n_i=2'b01 (bank 1 only).
- R5: A port-1 access to 0xFFE releases irq_p1_from_p2_n_o (high) with p1_bank_n_i=2'b10, and releases irq_p1_from_p3_n_o with 2'b01. An access is p1_wr_n_i=0 or p1_oe_n_i=0, so reads and writes both qualify.
- R6: A port-2 (port-3) access to 0xFFF with its chip enable low and its write strobe or output enable low releases irq_p2_n_o (irq_p3_n_o).
- R7: When a set and a clear condition for the same flag occur in the same cycle, the set wins and the output is low afterwards.
- R8: p1_bank_n_i=2'b00 is illegal: port 1 then neither sets nor clears any flag.
- R9: Accesses to other addresses, accesses with the port deselected, and selected cycles with both write strobe and output enable high change no flag.
- R10: With no qualifying access, every flag holds its value across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| p1_addr_i | input | ADDR_W | Port 1 address |
| p1_bank_n_i | input | 2 | Port 1 bank enables, bit 0 = bank 0, active low |
| p1_wr_n_i | input | 1 | Port 1 write strobe, active low |
| p1_oe_n_i | input | 1 | Port 1 output enable, active low |
| p2_addr_i | input | ADDR_W | Port 2 address |
| p2_ce_n_i | input | 1 | Port 2 chip enable, active low |
| p2_wr_n_i | input | 1 | Port 2 write strobe, active low |
| p2_oe_n_i | input | 1 | Port 2 output enable, active low |
| p3_addr_i | input | ADDR_W | Port 3 address |
| p3_ce_n_i | input | 1 | Port 3 chip enable, active low |
| p3_wr_n_i | input | 1 | Port 3 write strobe, active low |
| p3_oe_n_i | input | 1 | Port 3 output enable, active low |
| irq_p1_from_p2_n_o | output | 1 | Interrupt to port 1 raised by port 2, active low |
| irq_p1_from_p3_n_o | output | 1 | Interrupt to port 1 raised by port 3, active low |
| irq_p2_n_o | output | 1 | Interrupt to port 2 raised by port 1, active low |
| irq_p3_n_o | output | 1 | Interrupt to port 3 raised by port 1, active low |

## Verification
The properties assume that the port strobes are already synchronous to clk_i and settled at each sampling edge. They also treat one sampled cycle as one access, whatever the strobe pulse width at the memory. The clear and illegal-enable properties are qualified with the absence of a competing set, so they remain valid when traffic overlaps. The stimulus holds each access for exactly one clock and returns every strobe to idle between accesses. Overlaps appear only in the cases that are deliberately made coincident.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;

  localparam int unsigned NUM_FLAGS = 4;

  // lanes: 0 = port1 bank0, 1 = port1 bank1, 2 = port2, 3 = port3
  typedef enum logic [1:0] {
    LANE_P1_B0 = 2'd0,
    LANE_P1_B1 = 2'd1,
    LANE_P2    = 2'd2,
    LANE_P3    = 2'd3
  } lane_e;

  // flag k is cleared from lane k and set from its partner lane
  function automatic int unsigned set_lane(input int unsigned flag);
    return flag ^ 2;
  endfunction

  function automatic int unsigned clr_lane(input int unsigned flag);
    return flag;
  endfunction

  function automatic logic is_p1_lane(input int unsigned lane);
    return lane < 2;
  endfunction

endpackage

// File: rtl/mbox_lane_dec.sv
module mbox_lane_dec #(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] WR_ADDR  = '1,
  parameter logic [ADDR_W-1:0] ACC_ADDR = '1
) (
  input  logic              sel_i,
  input  logic              wr_n_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              set_o,
  output logic              clr_o
);

  logic is_write;
  logic is_access;

  assign is_write  = sel_i && !wr_n_i;
  assign is_access = sel_i && (!wr_n_i || !oe_n_i);

  assign set_o = is_write  && (addr_i == WR_ADDR);
  assign clr_o = is_access && (addr_i == ACC_ADDR);

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n_o
);

  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;   // set has priority
    else if (clr_i) flag_q <= 1'b0;
  end

  assign irq_n_o = ~flag_q;

endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] p1_addr_i,
  input  logic [1:0]        p1_bank_n_i,
  input  logic              p1_wr_n_i,
  input  logic              p1_oe_n_i,
  input  logic [ADDR_W-1:0] p2_addr_i,
  input  logic              p2_ce_n_i,
  input  logic              p2_wr_n_i,
  input  logic              p2_oe_n_i,
  input  logic [ADDR_W-1:0] p3_addr_i,
  input  logic              p3_ce_n_i,
  input  logic              p3_wr_n_i,
  input  logic              p3_oe_n_i,
  output logic              irq_p1_from_p2_n_o,
  output logic              irq_p1_from_p3_n_o,
  output logic              irq_p2_n_o,
  output logic              irq_p3_n_o
);
  import mbox_irq_pkg::*;

  localparam logic [ADDR_W-1:0] MBOX_PEER = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MBOX_P1   = MBOX_PEER - 1'b1;

  logic              lane_sel  [NUM_FLAGS];
  logic              lane_wr_n [NUM_FLAGS];
  logic              lane_oe_n [NUM_FLAGS];
  logic [ADDR_W-1:0] lane_addr [NUM_FLAGS];
  logic              lane_set  [NUM_FLAGS];
  logic              lane_clr  [NUM_FLAGS];
  logic              irq_n     [NUM_FLAGS];

  // exactly one bank enable low qualifies port 1
  assign lane_sel[LANE_P1_B0] = !p1_bank_n_i[0] &&  p1_bank_n_i[1];
  assign lane_sel[LANE_P1_B1] =  p1_bank_n_i[0] && !p1_bank_n_i[1];
  assign lane_sel[LANE_P2]    = !p2_ce_n_i;
  assign lane_sel[LANE_P3]    = !p3_ce_n_i;

  assign lane_wr_n[LANE_P1_B0] = p1_wr_n_i;
  assign lane_wr_n[LANE_P1_B1] = p1_wr_n_i;
  assign lane_wr_n[LANE_P2]    = p2_wr_n_i;
  assign lane_wr_n[LANE_P3]    = p3_wr_n_i;

  assign lane_oe_n[LANE_P1_B0] = p1_oe_n_i;
  assign lane_oe_n[LANE_P1_B1] = p1_oe_n_i;
  assign lane_oe_n[LANE_P2]    = p2_oe_n_i;
  assign lane_oe_n[LANE_P3]    = p3_oe_n_i;

  assign lane_addr[LANE_P1_B0] = p1_addr_i;
  assign lane_addr[LANE_P1_B1] = p1_addr_i;
  assign lane_addr[LANE_P2]    = p2_addr_i;
  assign lane_addr[LANE_P3]    = p3_addr_i;

  for (genvar l = 0; l < NUM_FLAGS; l++) begin : g_lane
    localparam logic [ADDR_W-1:0] WR_A  = is_p1_lane(l) ? MBOX_PEER : MBOX_P1;
    localparam logic [ADDR_W-1:0] ACC_A = is_p1_lane(l) ? MBOX_P1   : MBOX_PEER;
    mbox_lane_dec #(
      .ADDR_W  (ADDR_W),
      .WR_ADDR (WR_A),
      .ACC_ADDR(ACC_A)
    ) dec_i (
      .sel_i (lane_sel[l]),
      .wr_n_i(lane_wr_n[l]),
      .oe_n_i(lane_oe_n[l]),
      .addr_i(lane_addr[l]),
      .set_o (lane_set[l]),
      .clr_o (lane_clr[l])
    );
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    mbox_flag flag_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (lane_set[set_lane(f)]),
      .clr_i  (lane_clr[clr_lane(f)]),
      .irq_n_o(irq_n[f])
    );
  end

  assign irq_p1_from_p2_n_o = irq_n[0];
  assign irq_p1_from_p3_n_o = irq_n[1];
  assign irq_p2_n_o         = irq_n[2];
  assign irq_p3_n_o         = irq_n[3];

endmodule

// File: rtl/mbox_irq_ctrl_chk.sv
module mbox_irq_ctrl_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] p1_addr_i,
  input logic [1:0]        p1_bank_n_i,
  input logic              p1_wr_n_i,
  input logic              p1_oe_n_i,
  input logic [ADDR_W-1:0] p2_addr_i,
  input logic              p2_ce_n_i,
  input logic              p2_wr_n_i,
  input logic              p2_oe_n_i,
  input logic [ADDR_W-1:0] p3_addr_i,
  input logic              p3_ce_n_i,
  input logic              p3_wr_n_i,
  input logic              p3_oe_n_i,
  input logic              irq_p1_from_p2_n_o,
  input logic              irq_p1_from_p3_n_o,
  input logic              irq_p2_n_o,
  input logic              irq_p3_n_o
);

  localparam logic [ADDR_W-1:0] HI = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LO = HI - 1'b1;

  logic p1_acc, p2_acc, p3_acc;
  logic p2_w_lo, p3_w_lo, p1_w_hi_b0, p1_w_hi_b1;
  logic p2_c_hi, p3_c_hi;

  assign p1_acc = !p1_wr_n_i || !p1_oe_n_i;
  assign p2_acc = !p2_ce_n_i && (!p2_wr_n_i || !p2_oe_n_i);
  assign p3_acc = !p3_ce_n_i && (!p3_wr_n_i || !p3_oe_n_i);
  assign p2_w_lo    = !p2_ce_n_i && !p2_wr_n_i && p2_addr_i == LO;
  assign p3_w_lo    = !p3_ce_n_i && !p3_wr_n_i && p3_addr_i == LO;
  assign p1_w_hi_b0 = p1_bank_n_i == 2'b10 && !p1_wr_n_i && p1_addr_i == HI;
  assign p1_w_hi_b1 = p1_bank_n_i == 2'b01 && !p1_wr_n_i && p1_addr_i == HI;
  assign p2_c_hi    = p2_acc && p2_addr_i == HI;
  assign p3_c_hi    = p3_acc && p3_addr_i == HI;

  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_p1_from_p2_n_o && irq_p1_from_p3_n_o && irq_p2_n_o && irq_p3_n_o));

  a_r2_p2_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p2_w_lo |=> !irq_p1_from_p2_n_o);

  a_r3_p3_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p3_w_lo |=> !irq_p1_from_p3_n_o);

  a_r4_p1_raises_p2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p1_w_hi_b0 |=> !irq_p2_n_o);

  a_r4_p1_raises_p3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p1_w_hi_b1 |=> !irq_p3_n_o);

  a_r5_p1_clears_b0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_bank_n_i == 2'b10 && p1_acc && p1_addr_i == LO && !p2_w_lo) |=> irq_p1_from_p2_n_o);

  a_r5_p1_clears_b1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_bank_n_i == 2'b01 && p1_acc && p1_addr_i == LO && !p3_w_lo) |=> irq_p1_from_p3_n_o);

  a_r6_p2_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p2_c_hi && !p1_w_hi_b0) |=> irq_p2_n_o);

  a_r6_p3_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p3_c_hi && !p1_w_hi_b1) |=> irq_p3_n_o);

  a_r8_illegal_banks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_bank_n_i == 2'b00 && !p2_c_hi && !p3_c_hi) |=> ($stable(irq_p2_n_o) && $stable(irq_p3_n_o)));

endmodule

bind mbox_irq_ctrl mbox_irq_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/mbox_irq_ctrl_tb_top.sv
module mbox_irq_ctrl_tb_top;

  localparam int unsigned AW = 12;

  typedef struct packed {
    logic [AW-1:0] a1; logic [1:0] be1; logic w1; logic o1;
    logic [AW-1:0] a2; logic c2; logic w2; logic o2;
    logic [AW-1:0] a3; logic c3; logic w3; logic o3;
    logic [3:0]    exp;  // {p3, p2, p1_from_p3, p1_from_p2}, 1 = asserted
    logic [7:0]    rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{12'h000,2'b11,1,1, 12'hFFE,0,0,1, 12'h000,1,1,1, 4'b0001, 8'd2},  // R2 p2 writes FFE
    '{12'h000,2'b11,1,1, 12'h000,1,1,1, 12'hFFE,0,0,1, 4'b0011, 8'd3},  // R3 p3 writes FFE
    '{12'hFFF,2'b10,0,1, 12'h000,1,1,1, 12'h000,1,1,1, 4'b0111, 8'd4},  // R4 bank0 -> p2
    '{12'hFFF,2'b01,0,1, 12'h000,1,1,1, 12'h000,1,1,1, 4'b1111, 8'd4},  // R4 bank1 -> p3
    '{12'hFFE,2'b00,1,0, 12'h000,1,1,1, 12'h000,1,1,1, 4'b1111, 8'd8},  // R8 illegal read, no clear
    '{12'hFFE,2'b10,1,0, 12'h000,1,1,1, 12'h000,1,1,1, 4'b1110, 8'd5},  // R5 read clears p1_from_p2
    '{12'hFFE,2'b01,0,1, 12'h000,1,1,1, 12'h000,1,1,1, 4'b1100, 8'd5},  // R5 write clears p1_from_p3
    '{12'h000,2'b11,1,1, 12'hFFF,0,1,0, 12'h000,1,1,1, 4'b1000, 8'd6},  // R6 p2 read clears
    '{12'h000,2'b11,1,1, 12'h000,1,1,1, 12'hFFF,0,0,1, 4'b0000, 8'd6},  // R6 p3 write clears
    '{12'hFFF,2'b00,0,1, 12'h000,1,1,1, 12'h000,1,1,1, 4'b0000, 8'd8},  // R8 illegal write, no set
    '{12'h000,2'b11,1,1, 12'hFFD,0,0,1, 12'h000,1,1,1, 4'b0000, 8'd9},  // R9 wrong address
    '{12'h000,2'b11,1,1, 12'hFFE,1,0,1, 12'h000,1,1,1, 4'b0000, 8'd9},  // R9 deselected
    '{12'hFFE,2'b10,0,1, 12'hFFF,0,0,1, 12'h000,1,1,1, 4'b0000, 8'd9},  // R9 wrong mailbox per side
    '{12'h000,2'b11,1,1, 12'hFFE,0,0,1, 12'h000,1,1,1, 4'b0001, 8'd2},  // R2 again
    '{12'hFFE,2'b10,1,1, 12'h000,1,1,1, 12'h000,1,1,1, 4'b0001, 8'd9},  // R9 selected, no strobe
    '{12'h000,2'b11,1,1, 12'h000,1,1,1, 12'h000,1,1,1, 4'b0001, 8'd10}, // R10 hold
    '{12'hFFE,2'b10,1,0, 12'hFFE,0,0,1, 12'h000,1,1,1, 4'b0001, 8'd7},  // R7 set beats clear
    '{12'hFFF,2'b01,0,1, 12'h000,1,1,1, 12'hFFF,0,1,0, 4'b1001, 8'd7},  // R7 set beats clear
    '{12'h000,2'b11,1,1, 12'h000,1,1,1, 12'hFFF,0,1,0, 4'b0001, 8'd6},  // R6 p3 read clears
    '{12'hFFE,2'b10,1,0, 12'h000,1,1,1, 12'h000,1,1,1, 4'b0000, 8'd5}   // R5
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] p1_addr_i, p2_addr_i, p3_addr_i;
  logic [1:0]    p1_bank_n_i;
  logic          p1_wr_n_i, p1_oe_n_i;
  logic          p2_ce_n_i, p2_wr_n_i, p2_oe_n_i;
  logic          p3_ce_n_i, p3_wr_n_i, p3_oe_n_i;
  logic          irq_p1_from_p2_n_o, irq_p1_from_p3_n_o, irq_p2_n_o, irq_p3_n_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  mbox_irq_ctrl #(.ADDR_W(AW)) dut_i (.*);

  function automatic logic [3:0] flags();
    return ~{irq_p3_n_o, irq_p2_n_o, irq_p1_from_p3_n_o, irq_p1_from_p2_n_o};
  endfunction

  task automatic check(input int rq, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: flags=%b expected=%b at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic idle();
    p1_addr_i = '0; p1_bank_n_i = 2'b11; p1_wr_n_i = 1; p1_oe_n_i = 1;
    p2_addr_i = '0; p2_ce_n_i = 1; p2_wr_n_i = 1; p2_oe_n_i = 1;
    p3_addr_i = '0; p3_ce_n_i = 1; p3_wr_n_i = 1; p3_oe_n_i = 1;
  endtask

  task automatic apply(input vec_t v);
    p1_addr_i = v.a1; p1_bank_n_i = v.be1; p1_wr_n_i = v.w1; p1_oe_n_i = v.o1;
    p2_addr_i = v.a2; p2_ce_n_i = v.c2; p2_wr_n_i = v.w2; p2_oe_n_i = v.o2;
    p3_addr_i = v.a3; p3_ce_n_i = v.c3; p3_wr_n_i = v.w3; p3_oe_n_i = v.o3;
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    check(1, flags(), 4'b0000);  // R1 during reset
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(1, flags(), 4'b0000);  // R1 after release

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      @(negedge clk_i);
      idle();
      check(int'(VECS[i].rq), flags(), VECS[i].exp);
    end

    // R10: flag holds over several idle cycles
    repeat (5) @(negedge clk_i);
    check(10, flags(), 4'b0000);
    p1_addr_i = 12'hFFF; p1_bank_n_i = 2'b10; p1_wr_n_i = 0;  // R4 set p2 flag
    @(negedge clk_i);
    idle();
    repeat (6) @(negedge clk_i);
    check(10, flags(), 4'b0100);

    // R1: asynchronous reset clears mid-run, between edges
    #1 rst_ni = 1'b0;
    #1 check(1, flags(), 4'b0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1, flags(), 4'b0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule